// File: doc/BRIEF.md
# Parallel Port Handshake Controller

This block holds the handshake logic for one 8-bit bidirectional parallel port on the host side of an I/O interface. A CPU reaches it through a small register bus. The registers are port data, per-bit direction, control, interrupt flags and interrupt enables. On the peripheral side there are eight data pins, one edge-sensitive strobe input (CL1) and one control line (CL2). CL2 can listen as an input or drive as an output.

Any CPU access to the port data register can start an outgoing handshake. Both a read and a write count. CL2 then falls for exactly one clock in pulse mode. In handshake mode it stays low until the peripheral answers with an active CL1 edge. The CL1 edge also sets a sticky flag. Software learns that the peripheral is ready from that flag and from the active-low interrupt output. The CPU has no other view of the CL1 or CL2 levels.

Top module: `pport_hs_ctrl`

## Requirements
- R1: After reset, the following read as zero: data, direction, control, flag and enable registers. `pa_oe` is 0, `cl2_oe` is 0 (CL2 is an input), `cl2_out` is 1 and `irq_n` is 1.
- R2: Register addresses are 0 for port data, 1 for direction, 2 for control, 3 for flags and 4 for enables. A port-data write drives `pa_out`. Each direction bit set to 1 makes that pin an output on `pa_oe`. A port-data read returns `pa_in` on input bits and the written value on output bits.
- R3: Pulse mode is control bits [3:1] = 3'b011. Every read or write of port data drives `cl2_out` low in the cycle after the access, for exactly one cycle. Each repeated access makes a new pulse.
- R4: Handshake mode is control bits [3:1] = 3'b010. A port-data access drives `cl2_out` low and holds it low until an active CL1 edge is detected. A CL1 edge that coincides with a port access leaves CL2 low.
- R5: Control bit 0 selects the active CL1 edge: 1 for rising, 0 for falling. `cl1_in` passes through two synchronizer stages. An active edge sets flag bit 0, which is visible three clocks after the pin changes. The flag stays set across further edges. The opposite edge does nothing.
- R6: A port-data read or write clears flag bits 1:0. Writing 1 to a flag bit clears that bit, and writing 0 leaves it unchanged. A flag being set in the same cycle as a clear stays set.
- R7: The enable register uses bits 1:0. Flag register bit 7 reads as the OR of all flags that are both set and enabled. `irq_n` is low exactly when that bit is 1.
- R8: Control bits [3:1] = 3'b000, 3'b001, 3'b110 and 3'b111 make CL2 an input (`cl2_oe` = 0). A CL2 edge then sets flag bit 1: a falling edge when bit 1 of the control register is 0, a rising edge when it is 1.
- R9: Control bits [3:1] = 3'b100 drive `cl2_out` low and 3'b101 drive it high. In both, `cl2_oe` = 1, and port accesses have no effect on CL2.
- R10: A write to the control register cancels any pending pulse or handshake low. CL2 then shows the idle level of the new mode on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| pa_in | input | 8 | Port pin input levels |
| pa_out | output | 8 | Port output data |
| pa_oe | output | 8 | Port per-bit output enable |
| cl1_in | input | 1 | Peripheral strobe input |
| cl2_in | input | 1 | Control line input level |
| cl2_out | output | 1 | Control line output level |
| cl2_oe | output | 1 | Control line output enable |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Some properties are checked on every cycle:
- A port access in either output mode pulls CL2 low and enables it on the next cycle.
- A pulse-mode low that no new access renews lasts a single cycle.
- A handshake-mode low persists until a detected CL1 edge, and that edge releases it.
- Every detected CL1 edge leaves flag bit 0 set.

Other behaviour only the bench scenarios show:
- The three-cycle synchronizer latency and polarity selection, seen at the pins.
- The readback mix of pin and output data.
- Write-one-to-clear against clear-on-access.
- Priority of an edge that lands on the same cycle as a port access.
- Interrupt masking.
- The input and manual CL2 modes.

// File: rtl/pport_hs_pkg.sv
package pport_hs_pkg;

  localparam int unsigned REG_AW = 3;

  localparam logic [REG_AW-1:0] ADDR_DATA = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_DIR  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_FLAG = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_IEN  = 3'd4;

  localparam int unsigned NFLAG    = 2;
  localparam int unsigned FLG_CL1  = 0;
  localparam int unsigned FLG_CL2  = 1;
  localparam int unsigned CTRL_W   = 4;

  typedef enum logic [2:0] {
    CL2_IN_FALL  = 3'b000,
    CL2_IN_RISE  = 3'b001,
    CL2_HSHAKE   = 3'b010,
    CL2_PULSE    = 3'b011,
    CL2_FORCE_LO = 3'b100,
    CL2_FORCE_HI = 3'b101,
    CL2_IN_FALL2 = 3'b110,
    CL2_IN_RISE2 = 3'b111
  } cl2_mode_e;

  function automatic logic cl2_is_input(input logic [2:0] m);
    return (m[2:1] == 2'b00) || (m[2:1] == 2'b11);
  endfunction

endpackage

// File: rtl/pport_edge_sync.sv
module pport_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] shf_q, shf_d;
  logic [DEPTH-1:0] arm_q, arm_d;

  always_comb begin
    shf_d = {shf_q[DEPTH-2:0], pin_i};
    arm_d = {arm_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shf_q <= '0;
      arm_q <= '0;
    end else begin
      shf_q <= shf_d;
      arm_q <= arm_d;
    end
  end

  logic cur, prv;
  assign cur = shf_q[DEPTH-2];
  assign prv = shf_q[DEPTH-1];

  always_comb begin
    if (!arm_q[DEPTH-1]) edge_o = 1'b0;
    else if (rise_sel_i) edge_o = cur & ~prv;
    else                 edge_o = ~cur & prv;
  end
endmodule

// File: rtl/pport_cl2_ctrl.sv
module pport_cl2_ctrl
  import pport_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       port_acc_i,
  input  logic       ctrl_wr_i,
  input  logic       cl1_edge_i,
  output logic       cl2_out_o,
  output logic       cl2_oe_o
);
  logic hs_low_q, hs_low_d;
  logic pl_low_q, pl_low_d;
  logic hs_en, pl_en;

  assign hs_en = (mode_i == CL2_HSHAKE);
  assign pl_en = (mode_i == CL2_PULSE);

  always_comb begin
    hs_low_d = hs_low_q;
    pl_low_d = 1'b0;
    if (ctrl_wr_i) begin
      hs_low_d = 1'b0;
    end else begin
      if (hs_en && port_acc_i)      hs_low_d = 1'b1;
      else if (!hs_en)              hs_low_d = 1'b0;
      else if (cl1_edge_i)          hs_low_d = 1'b0;
      pl_low_d = pl_en && port_acc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_low_q <= 1'b0;
      pl_low_q <= 1'b0;
    end else begin
      hs_low_q <= hs_low_d;
      pl_low_q <= pl_low_d;
    end
  end

  always_comb begin
    cl2_oe_o = !cl2_is_input(mode_i);
    unique case (mode_i)
      CL2_HSHAKE:   cl2_out_o = ~hs_low_q;
      CL2_PULSE:    cl2_out_o = ~pl_low_q;
      CL2_FORCE_LO: cl2_out_o = 1'b0;
      default:      cl2_out_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pport_irq_flags.sv
module pport_irq_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ien_i,
  output logic [N-1:0] flags_o,
  output logic         irq_any_o
);
  logic [N-1:0] flg_q, flg_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      if (set_i[i])      flg_d[i] = 1'b1;
      else if (clr_i[i]) flg_d[i] = 1'b0;
      else               flg_d[i] = flg_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags_o   = flg_q;
  assign irq_any_o = |(flg_q & ien_i);
endmodule

// File: rtl/pport_hs_ctrl.sv
module pport_hs_ctrl
  import pport_hs_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     pa_in,
  output logic [DW-1:0]     pa_out,
  output logic [DW-1:0]     pa_oe,
  input  logic              cl1_in,
  input  logic              cl2_in,
  output logic              cl2_out,
  output logic              cl2_oe,
  output logic              irq_n
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  // bus decode
  logic wr_en, port_acc, ctrl_wr;
  assign wr_en    = bus_sel & bus_wr;
  assign port_acc = bus_sel & (bus_addr == ADDR_DATA);
  assign ctrl_wr  = wr_en & (bus_addr == ADDR_CTRL);

  // register state
  logic [DW-1:0]     out_q, out_d;
  logic [DW-1:0]     dir_q, dir_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NFLAG-1:0]  ien_q, ien_d;

  always_comb begin
    out_d  = out_q;
    dir_d  = dir_q;
    ctrl_d = ctrl_q;
    ien_d  = ien_q;
    if (wr_en) begin
      unique case (bus_addr)
        ADDR_DATA: out_d  = bus_wdata;
        ADDR_DIR:  dir_d  = bus_wdata;
        ADDR_CTRL: ctrl_d = bus_wdata[CTRL_W-1:0];
        ADDR_IEN:  ien_d  = bus_wdata[NFLAG-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      out_q  <= '0;
      dir_q  <= '0;
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      ctrl_q <= ctrl_d;
      ien_q  <= ien_d;
    end
  end

  logic [2:0] cl2_mode;
  logic       cl1_rise_sel;
  assign cl2_mode     = ctrl_q[3:1];
  assign cl1_rise_sel = ctrl_q[0];

  // strobe edge detectors
  logic cl1_edge, cl2_edge;

  pport_edge_sync #(.STAGES(SYNC_STAGES)) u_cl1_sync (
    .clk       (clk),
    .rst_n     (rst_i),
    .pin_i     (cl1_in),
    .rise_sel_i(cl1_rise_sel),
    .edge_o    (cl1_edge)
  );

  pport_edge_sync #(.STAGES(SYNC_STAGES)) u_cl2_sync (
    .clk       (clk),
    .rst_n     (rst_i),
    .pin_i     (cl2_in),
    .rise_sel_i(cl2_mode[0]),
    .edge_o    (cl2_edge)
  );

  // control line output
  pport_cl2_ctrl u_cl2 (
    .clk       (clk),
    .rst_n     (rst_i),
    .mode_i    (cl2_mode),
    .port_acc_i(port_acc),
    .ctrl_wr_i (ctrl_wr),
    .cl1_edge_i(cl1_edge),
    .cl2_out_o (cl2_out),
    .cl2_oe_o  (cl2_oe)
  );

  // flags and interrupt
  logic [NFLAG-1:0] flg_set, flg_clr, flags;
  logic             irq_any;

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_CL1] = cl1_edge;
    flg_set[FLG_CL2] = cl2_edge & cl2_is_input(cl2_mode);
    flg_clr          = {NFLAG{port_acc}};
    if (wr_en && (bus_addr == ADDR_FLAG)) flg_clr = flg_clr | bus_wdata[NFLAG-1:0];
  end

  pport_irq_flags #(.N(NFLAG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_i),
    .set_i    (flg_set),
    .clr_i    (flg_clr),
    .ien_i    (ien_q),
    .flags_o  (flags),
    .irq_any_o(irq_any)
  );

  assign irq_n  = ~irq_any;
  assign pa_out = out_q;
  assign pa_oe  = dir_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = (pa_in & ~dir_q) | (out_q & dir_q);
      ADDR_DIR:  bus_rdata = dir_q;
      ADDR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_FLAG: begin
        bus_rdata[NFLAG-1:0] = flags;
        bus_rdata[DW-1]      = irq_any;
      end
      ADDR_IEN:  bus_rdata[NFLAG-1:0] = ien_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/pport_hs_ctrl_chk.sv
module pport_hs_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       port_acc,
  input logic       ctrl_wr,
  input logic       cl1_edge,
  input logic       cl2_out,
  input logic       cl2_oe,
  input logic [1:0] flags
);
  // R3, R4: an access in an output handshake mode pulls CL2 low next cycle
  a_r3_access_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (port_acc && (mode == 3'b010 || mode == 3'b011)) |=> (!cl2_out && cl2_oe));

  // R3: a pulse not renewed by an access lasts one cycle
  a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b011 && !cl2_out && !port_acc && !ctrl_wr) |=> cl2_out);

  // R4: handshake low holds until a CL1 edge
  a_r4_hs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010 && !cl2_out && !cl1_edge && !ctrl_wr) |=> !cl2_out);

  // R4: a CL1 edge with no access releases the line
  a_r4_hs_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010 && cl1_edge && !port_acc && !ctrl_wr) |=> cl2_out);

  // R5, R6: a detected edge always leaves the flag set
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    cl1_edge |=> flags[0]);
endmodule

bind pport_hs_ctrl pport_hs_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_i),
  .mode    (cl2_mode),
  .port_acc(port_acc),
  .ctrl_wr (ctrl_wr),
  .cl1_edge(cl1_edge),
  .cl2_out (cl2_out),
  .cl2_oe  (cl2_oe),
  .flags   (flags)
);

// File: tb/pport_hs_ctrl_tb.sv
`timescale 1ns/1ps
module pport_hs_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pa_in = '0, pa_out, pa_oe;
  logic cl1_in = 1'b1, cl2_in = 1'b1;
  logic cl2_out, cl2_oe, irq_n;

  always #4 clk = ~clk;

  pport_hs_ctrl dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_out = 0, m_dir = 0;
  logic [3:0] m_ctrl = 0;
  logic [1:0] m_flags = 0, m_ien = 0;
  logic       m_hs_low = 0;

  function automatic logic [2:0] m_mode(); return m_ctrl[3:1]; endfunction
  function automatic logic m_in_mode();
    return (m_mode() inside {3'b000, 3'b001, 3'b110, 3'b111});
  endfunction
  function automatic logic exp_cl2();
    case (m_mode())
      3'b010: return !m_hs_low;
      3'b100: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction
  function automatic logic exp_any(); return |(m_flags & m_ien); endfunction
  function automatic logic [7:0] exp_port(); return (pa_in & ~m_dir) | (m_out & m_dir); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_do(logic wr, logic [2:0] a, logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic after_port_access();
    m_flags = 0;
    if (m_mode() == 3'b010) m_hs_low = 1;
    if (m_mode() == 3'b011 || m_mode() == 3'b010) begin
      chk("R3_R4 access low", {cl2_oe, cl2_out}, 2'b10);
    end else begin
      chk("R9 no effect", {cl2_oe, cl2_out}, {!m_in_mode(), exp_cl2()});
    end
    if (m_mode() == 3'b011) begin
      @(negedge clk);
      chk("R3 pulse one cycle", cl2_out, 1'b1);
    end
  endtask

  task automatic do_wr_port(logic [7:0] d);
    logic [7:0] rd;
    bus_do(1, 3'd0, d, rd);
    m_out = d;
    chk("R2 pa_out", pa_out, d);
    after_port_access();
  endtask

  task automatic do_rd_port();
    logic [7:0] rd;
    logic [7:0] e;
    e = exp_port();
    bus_do(0, 3'd0, 0, rd);
    chk("R2 port read", rd, e);
    after_port_access();
  endtask

  task automatic do_wr_reg(logic [2:0] a, logic [7:0] d);
    logic [7:0] rd;
    bus_do(1, a, d, rd);
    case (a)
      3'd1: m_dir = d;
      3'd2: begin m_ctrl = d[3:0]; m_hs_low = 0; end
      3'd3: m_flags = m_flags & ~d[1:0];
      3'd4: m_ien = d[1:0];
      default: ;
    endcase
    if (a == 3'd1) chk("R2 pa_oe", pa_oe, d);
    if (a == 3'd2) chk("R10 R8 R9 cl2 idle", {cl2_oe, cl2_out}, {!m_in_mode(), exp_cl2()});
  endtask

  task automatic do_rd_flags(string tag);
    logic [7:0] rd;
    bus_do(0, 3'd3, 0, rd);
    chk({tag, " R6 R7 flag reg"}, rd, {exp_any(), 5'b0, m_flags});
    chk("R7 irq_n", irq_n, !exp_any());
  endtask

  task automatic do_cl1(logic v);
    logic old;
    old = cl1_in;
    @(negedge clk) cl1_in = v;
    repeat (4) @(negedge clk);
    if (old != v && v == m_ctrl[0]) begin
      m_flags[0] = 1;
      if (m_mode() == 3'b010) m_hs_low = 0;
    end
    chk("R4 R5 cl2 after cl1", cl2_out, exp_cl2());
  endtask

  task automatic do_cl2(logic v);
    logic old;
    old = cl2_in;
    @(negedge clk) cl2_in = v;
    repeat (4) @(negedge clk);
    if (old != v && m_in_mode() && v == m_ctrl[1]) m_flags[1] = 1;
    chk("R8 cl2 input oe", cl2_oe, !m_in_mode());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk("R1 cl2_oe", cl2_oe, 0);
    chk("R1 cl2_out", cl2_out, 1);
    chk("R1 pa_oe", pa_oe, 0);
    chk("R1 irq_n", irq_n, 1);
    bus_do(0, 3'd2, 0, rd); chk("R1 ctrl", rd, 0);
    bus_do(0, 3'd3, 0, rd); chk("R1 flags", rd, 0);

    // R2 mixed direction readback
    do_wr_reg(1, 8'h0F);
    pa_in = 8'h3C;
    do_wr_port(8'hA5);
    bus_do(0, 3'd0, 0, rd); chk("R2 mixed read", rd, 8'h35);
    m_flags = 0;

    // R3 back-to-back reads each pulse
    do_wr_reg(2, 4'b0110);
    do_rd_port();
    do_rd_port();

    // R4 handshake with rising CL1
    do_wr_reg(2, 4'b0101);
    do_wr_port(8'h11);
    repeat (5) @(negedge clk);
    chk("R4 held low", cl2_out, 0);
    do_cl1(0);
    chk("R4 falling ignored", cl2_out, 0);
    do_rd_flags("R5 opposite edge");
    do_cl1(1);
    chk("R4 released by edge", cl2_out, 1);
    do_rd_flags("R5 rising set");

    // R6 write-one-to-clear, write zero ignored
    do_wr_reg(3, 8'h00); do_rd_flags("R6 w0");
    do_wr_reg(3, 8'h01); do_rd_flags("R6 w1");

    // R4 R6 edge coinciding with port access
    do_cl1(0);
    @(negedge clk) cl1_in = 1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 0;
    @(negedge clk);
    bus_sel = 0;
    m_flags = 2'b01; m_hs_low = 1;
    chk("R4 access wins over release", cl2_out, 0);
    do_rd_flags("R6 set wins");

    // R7 enable
    do_wr_reg(4, 8'h01); do_rd_flags("R7 enabled");
    chk("R7 irq low", irq_n, 0);

    // R9 manual modes
    do_wr_reg(2, 4'b1000); do_wr_port(8'h22);
    do_wr_reg(2, 4'b1010); do_rd_port();

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 8);
      pa_in = 8'($urandom);
      case (op)
        0: do_wr_port(8'($urandom));
        1: do_rd_port();
        2, 3: do_cl1(1'($urandom));
        4: do_rd_flags("rand");
        5: do_wr_reg(3, 8'($urandom));
        6: do_wr_reg(2, 8'($urandom));
        7: begin do_wr_reg(4, 8'($urandom)); do_wr_reg(1, 8'($urandom)); end
        default: do_cl2(1'($urandom));
      endcase
    end
    do_rd_flags("final");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule